// File: doc/BRIEF.md
# Software-Generated Interrupt Request Router

This block sits between the CPUs of a cluster and their per-CPU interrupt pending logic. When a CPU writes a 64-bit request word to one of three generation registers, the block works out which CPUs should receive a software-generated interrupt (SGI). It then issues a one-cycle delivery pulse to each of those CPUs. With every pulse it supplies the interrupt number, the interrupt group and the security state of the CPU that made the request. Each target decides for itself whether to accept the interrupt; that check is not part of this block.

There are two ways to choose targets. A broadcast request reaches every CPU except the one that made it. A directed request names a three-level affinity prefix and a 16-bit bitmap over the lowest affinity level. The group of the interrupt follows from the register written and the requester's security state. A global flag that disables security folds secure group 1 into group 0.

Requests arrive as a plain write strobe and leave as a plain pulse vector. No back-pressure is possible: every accepted write produces exactly one delivery cycle, which follows it immediately.

Top module: `sgi_router`

## Requirements
- R1: The interrupt number on `dlv_id` is taken from write-data bits 27:24.
- R2: When write-data bit 40 is 1 (broadcast), every CPU except the one at `req_index` is targeted. Bits 15:0, 23:16, 39:32 and 55:48 have no effect on the targets.
- R3: When bit 40 is 0, a CPU is targeted only if bits 31:8 of its affinity word equal {data[55:48], data[39:32], data[23:16]}.
- R4: When bit 40 is 0 and the prefix matches, a CPU is targeted only if its affinity bits 7:0 (the lowest level, L) satisfy L <= 15 and data bit L is 1. A CPU with L > 15 is never targeted by a directed request.
- R5: Group codes are 0 for group 0, 1 for secure group 1 and 2 for non-secure group 1. The `wr_sel` values select the group as follows:
  - `wr_sel`=0 gives group 0.
  - `wr_sel`=1 gives group 1 of the requester's own state: code 2 if `req_nonsecure`, else code 1.
  - `wr_sel`=2 gives group 1 of the other state: code 1 if `req_nonsecure`, else code 2.
- R6: While `sec_disable` is 1, a request that would be secure group 1 (code 1) is delivered as group 0 (code 0).
- R7: `dlv_ns` equals the requester's `req_nonsecure` at the time of the write, whatever group was chosen.
- R8: `dlv_vec` is asserted for exactly one cycle, in the cycle after the write strobe. `dlv_id`, `dlv_grp` and `dlv_ns` are valid in that cycle and hold their values until the next accepted write. `dlv_vec` is 0 in every cycle that does not follow an accepted write.
- R9: A write with `wr_sel`=3, or a cycle with `wr_en` low, produces no delivery and leaves `dlv_id`, `dlv_grp` and `dlv_ns` unchanged.
- R10: After reset, `dlv_vec`, `dlv_id`, `dlv_grp` and `dlv_ns` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe to a generation register |
| wr_sel | input | 2 | Register written: 0 = group 0, 1 = group 1 own state, 2 = group 1 other state, 3 = none |
| wr_data | input | 64 | Request word |
| req_nonsecure | input | 1 | Requester is in the non-secure state |
| req_index | input | IDXW | Index of the requesting CPU |
| sec_disable | input | 1 | Global security-disable flag |
| cpu_aff | input | NCPU*32 | Affinity word per CPU, {L3,L2,L1,L0} in bits 32*i+31 down to 32*i |
| dlv_vec | output | NCPU | Per-CPU delivery pulse |
| dlv_id | output | 4 | Interrupt number |
| dlv_grp | output | 2 | Group code |
| dlv_ns | output | 1 | Requester non-secure flag |

## Verification
The assertions check four properties on every cycle:
- a delivery never occurs without a write in the previous cycle;
- a broadcast never reaches its requester;
- a directed delivery never reaches a CPU whose lowest affinity level is above 15;
- a group code of 3 never appears, and code 1 never appears while security is disabled.

Only the bench's sweeps can show the rest, because checking it needs the full expected value:
- that the target set is exactly the expected one for each prefix and bitmap;
- that broadcast ignores the affinity fields;
- that the register-select and security-state mapping gives the right group.

// File: rtl/sgi_rt_pkg.sv
package sgi_rt_pkg;

  localparam int DATA_W   = 64;
  localparam int ID_W     = 4;
  localparam int TLIST_W  = 16;
  localparam int AFF_W    = 8;
  localparam int PFX_W    = 3 * AFF_W;
  localparam int AFFWORD_W = 4 * AFF_W;

  // bit positions of the request word fields
  localparam int TLIST_LSB = 0;
  localparam int L1_LSB    = 16;
  localparam int ID_LSB    = 24;
  localparam int L2_LSB    = 32;
  localparam int BCAST_BIT = 40;
  localparam int L3_LSB    = 48;

  typedef enum logic [1:0] {
    GRP_ZERO   = 2'd0,
    GRP_SEC1   = 2'd1,
    GRP_NSEC1  = 2'd2
  } grp_e;

  typedef enum logic [1:0] {
    SEL_GRP0    = 2'd0,
    SEL_GRP1OWN = 2'd1,
    SEL_GRP1ALT = 2'd2,
    SEL_NONE    = 2'd3
  } sel_e;

  typedef struct packed {
    logic [ID_W-1:0]    id;
    logic               bcast;
    logic [PFX_W-1:0]   prefix;
    logic [TLIST_W-1:0] tlist;
  } req_t;

  function automatic req_t unpack_req(input logic [DATA_W-1:0] d);
    req_t r;
    r.id     = d[ID_LSB +: ID_W];
    r.bcast  = d[BCAST_BIT];
    r.prefix = {d[L3_LSB +: AFF_W], d[L2_LSB +: AFF_W], d[L1_LSB +: AFF_W]};
    r.tlist  = d[TLIST_LSB +: TLIST_W];
    return r;
  endfunction

endpackage

// File: rtl/sgi_rt_decode.sv
module sgi_rt_decode
  import sgi_rt_pkg::*;
(
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_sel,
  input  logic              req_nonsecure,
  input  logic              sec_disable,
  output req_t              req,
  output logic [1:0]        grp,
  output logic              sel_ok
);

  grp_e grp_raw;
  grp_e grp_fold;
  logic unused_bits;

  assign unused_bits = ^{wr_data[63:56], wr_data[47:41], wr_data[31:28]};
  assign req = unpack_req(wr_data);

  always_comb begin
    sel_ok  = 1'b1;
    grp_raw = GRP_ZERO;
    unique case (sel_e'(wr_sel))
      SEL_GRP0:    grp_raw = GRP_ZERO;
      SEL_GRP1OWN: grp_raw = req_nonsecure ? GRP_NSEC1 : GRP_SEC1;
      SEL_GRP1ALT: grp_raw = req_nonsecure ? GRP_SEC1 : GRP_NSEC1;
      default: begin
        sel_ok  = 1'b0;
        grp_raw = GRP_ZERO;
      end
    endcase
  end

  always_comb begin
    grp_fold = grp_raw;
    if (sec_disable && grp_raw == GRP_SEC1) grp_fold = GRP_ZERO;
  end

  assign grp = grp_fold;

endmodule

// File: rtl/sgi_rt_match.sv
module sgi_rt_match
  import sgi_rt_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int IDXW = (NCPU > 1) ? $clog2(NCPU) : 1
)(
  input  req_t                  req,
  input  logic [IDXW-1:0]       req_index,
  input  logic [NCPU*AFFWORD_W-1:0] cpu_aff,
  output logic [NCPU-1:0]       hit
);

  localparam int L0_HI_W = AFF_W - $clog2(TLIST_W);

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic [AFFWORD_W-1:0] word;
    logic [PFX_W-1:0]     pfx;
    logic [AFF_W-1:0]     lvl0;
    logic                 is_self;
    logic                 lvl0_ok;
    logic                 directed;

    assign word    = cpu_aff[i*AFFWORD_W +: AFFWORD_W];
    assign pfx     = word[AFFWORD_W-1:AFF_W];
    assign lvl0    = word[AFF_W-1:0];
    assign is_self = (int'(req_index) == i);
    assign lvl0_ok = (lvl0[AFF_W-1 -: L0_HI_W] == '0);
    assign directed = (pfx == req.prefix) && lvl0_ok &&
                      req.tlist[lvl0[$clog2(TLIST_W)-1:0]];

    assign hit[i] = req.bcast ? !is_self : directed;
  end

endmodule

// File: rtl/sgi_router.sv
module sgi_router
  import sgi_rt_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int IDXW = (NCPU > 1) ? $clog2(NCPU) : 1
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_sel,
  input  logic [63:0]               wr_data,
  input  logic                      req_nonsecure,
  input  logic [IDXW-1:0]           req_index,
  input  logic                      sec_disable,
  input  logic [NCPU*32-1:0]        cpu_aff,
  output logic [NCPU-1:0]           dlv_vec,
  output logic [3:0]                dlv_id,
  output logic [1:0]                dlv_grp,
  output logic                      dlv_ns
);

  req_t            req;
  logic [1:0]      grp_c;
  logic            sel_ok;
  logic [NCPU-1:0] hit;
  logic            accept;

  sgi_rt_decode u_dec (
    .wr_data      (wr_data),
    .wr_sel       (wr_sel),
    .req_nonsecure(req_nonsecure),
    .sec_disable  (sec_disable),
    .req          (req),
    .grp          (grp_c),
    .sel_ok       (sel_ok)
  );

  sgi_rt_match #(.NCPU(NCPU), .IDXW(IDXW)) u_match (
    .req      (req),
    .req_index(req_index),
    .cpu_aff  (cpu_aff),
    .hit      (hit)
  );

  assign accept = wr_en && sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_vec <= '0;
      dlv_id  <= '0;
      dlv_grp <= '0;
      dlv_ns  <= 1'b0;
    end else begin
      dlv_vec <= accept ? hit : '0;
      if (accept) begin
        dlv_id  <= req.id;
        dlv_grp <= grp_c;
        dlv_ns  <= req_nonsecure;
      end
    end
  end

  // R8
  pulse_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_vec != '0) |-> $past(wr_en));

  // R9
  idle_holds_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (dlv_vec == '0) && $stable(dlv_id) && $stable(dlv_grp) && $stable(dlv_ns));

  // R5
  no_bad_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_vec != '0) |-> (dlv_grp != 2'd3));

  // R6
  no_sec1_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sec_disable) |=> (dlv_grp != 2'd1));

  // R7
  ns_follows_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (dlv_ns == $past(req_nonsecure)));

  for (genvar i = 0; i < NCPU; i++) begin : g_chk
    // R2
    bcast_skips_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && wr_data[BCAST_BIT] && int'(req_index) == i) |=> !dlv_vec[i]);
    // R4
    lvl0_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !wr_data[BCAST_BIT] && cpu_aff[i*32 +: 8] > 8'd15) |=> !dlv_vec[i]);
  end

endmodule

// File: tb/sgi_router_test.sv
module sgi_router_test;

  localparam int NCPU = 4;
  localparam int IDXW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_sel = '0;
  logic [63:0]       wr_data = '0;
  logic              req_nonsecure = 1'b0;
  logic [IDXW-1:0]   req_index = '0;
  logic              sec_disable = 1'b0;
  logic [NCPU*32-1:0] cpu_aff;
  logic [NCPU-1:0]   dlv_vec;
  logic [3:0]        dlv_id;
  logic [1:0]        dlv_grp;
  logic              dlv_ns;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // CPU affinities: three share prefix 1.2.3, one has L0 = 20, one differs in L1
  assign cpu_aff = {8'd1, 8'd2, 8'd4, 8'd5,
                    8'd1, 8'd2, 8'd3, 8'd20,
                    8'd1, 8'd2, 8'd3, 8'd5,
                    8'd1, 8'd2, 8'd3, 8'd0};

  sgi_router #(.NCPU(NCPU), .IDXW(IDXW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_nonsecure(req_nonsecure), .req_index(req_index), .sec_disable(sec_disable),
    .cpu_aff(cpu_aff), .dlv_vec(dlv_vec), .dlv_id(dlv_id), .dlv_grp(dlv_grp),
    .dlv_ns(dlv_ns)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_vec(input logic [63:0] d, input int self);
    logic [3:0] v = '0;
    for (int i = 0; i < NCPU; i++) begin
      int l0 = cpu_aff[i*32 +: 8];
      if (d[40]) v[i] = (i != self);
      else if (cpu_aff[i*32+8 +: 24] == {d[55:48], d[39:32], d[23:16]} && l0 <= 15)
        v[i] = d[l0];
    end
    return v;
  endfunction

  function automatic int exp_grp(input int sel, input bit ns, input bit dis);
    int g;
    case (sel)
      0: g = 0;
      1: g = ns ? 2 : 1;
      default: g = ns ? 1 : 2;
    endcase
    if (dis && g == 1) g = 0;
    return g;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] tls [4] = '{16'h0021, 16'h0001, 16'hFFFF, 16'h0000};
    logic [23:0] pfxs [3] = '{24'h010203, 24'h010204, 24'h090909};
    int last_id = 0, last_grp = 0, last_ns = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 vec", dlv_vec, 0);
    check("R10 id", dlv_id, 0);
    check("R10 grp", dlv_grp, 0);
    check("R10 ns", dlv_ns, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle vec", dlv_vec, 0);
    for (int sel = 0; sel < 4; sel++)
      for (int ns = 0; ns < 2; ns++)
        for (int dis = 0; dis < 2; dis++)
          for (int bc = 0; bc < 2; bc++)
            for (int rq = 0; rq < NCPU; rq++)
              for (int t = 0; t < 4; t++)
                for (int p = 0; p < 3; p++) begin
                  logic [63:0] d;
                  int id;
                  id = (sel * 5 + rq * 3 + t + p) % 16;
                  d = {8'hA5, pfxs[p][23:16], 7'h55, bc[0], pfxs[p][15:8],
                       4'hC, id[3:0], pfxs[p][7:0], tls[t]};
                  wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = d;
                  req_nonsecure = ns[0]; req_index = rq[1:0]; sec_disable = dis[0];
                  @(negedge clk);
                  wr_en = 1'b0; wr_data = ~d; req_nonsecure = ~ns[0];
                  if (sel == 3) begin
                    check("R9 sel3 vec", dlv_vec, 0);
                    check("R9 sel3 id hold", dlv_id, last_id);
                    check("R9 sel3 grp hold", dlv_grp, last_grp);
                    check("R9 sel3 ns hold", dlv_ns, last_ns);
                  end else begin
                    last_id = id; last_grp = exp_grp(sel, ns[0], dis[0]); last_ns = ns;
                    if (bc != 0) check("R2 broadcast vec", dlv_vec, exp_vec(d, rq));
                    else if (p == 0) check("R4 directed L0 vec", dlv_vec, exp_vec(d, rq));
                    else check("R3 prefix vec", dlv_vec, exp_vec(d, rq));
                    check("R1 id", dlv_id, id);
                    if (dis != 0) check("R6 grp fold", dlv_grp, last_grp);
                    else check("R5 grp", dlv_grp, last_grp);
                    check("R7 ns", dlv_ns, ns);
                  end
                  @(negedge clk);
                  check("R8 pulse width", dlv_vec, 0);
                  check("R8 id hold", dlv_id, last_id);
                  check("R8 grp hold", dlv_grp, last_grp);
                end
    // R2: broadcast with all affinity and list bits flipped still yields the same set
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 64'h00FF_01FF_00FF_FFFF; req_index = 2'd2;
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 broadcast ignores fields", dlv_vec, 4'b1011);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule